// File: doc/BRIEF.md
# Threshold-Corrected FIR with Reliable Estimator

This block runs two copies of one fixed 4-tap FIR filter side by side. The full-precision path is sized for the average case and may now and then deliver a corrupted output. A test input models this by flipping chosen bits of that path's result. The second path is a narrow copy of the filter: it keeps only the top bits of every sample and every coefficient, and no corruption can reach it. Its result is shifted back to the full-precision scale.

For every accepted sample the block measures how far apart the two results are. If the gap is larger than a programmable threshold, the precise result is treated as broken and the coarse estimate goes out in its place. Otherwise the precise result passes through unchanged. The block never knows the real size of an error, so a replaced output is only approximately correct.

A "replaced" flag marks each substituted output. A saturating counter keeps a running total of substitutions. Both paths and the threshold move through the same two-stage pipeline, so the output always belongs to a single input sample.

Top module: `anc_corrector`

## Requirements
- R1: While reset is held, and on the first cycle after it, `out_valid`, `out_replaced`, `out_data` and `repl_count` are all zero. The tap history of both filters is cleared to zero.
- R2: A sample accepted with `in_valid` high on one rising edge produces `out_valid` high after the following rising edge. The output appears two edges after the sample is applied, and both paths always deliver in the same cycle.
- R3: The precise result is y = sum over k = 0..3 of c[k]·x[n−k]. The coefficients are c = {23, −57, 101, −128} for k = 0..3, x are signed 12-bit samples, and x[n−k] counts only samples that were accepted. The result is a signed 22-bit value and never overflows.
- R4: The estimate is e = 256 · sum over k of (c[k] >>> 2)·(x[n−k] >>> 6), using arithmetic shifts. This is the upper 6 bits of each coefficient and sample, realigned to the scale of y.
- R5: Let d = |y' − e|, where y' is the precise result after any injection. If d > `th`, the output is e and `out_replaced` is 1. If d ≤ `th`, including d equal to `th`, the output is y' and `out_replaced` is 0. `th` is unsigned and is sampled together with the input sample.
- R6: When `inj_en` is high with an accepted sample, y' = y XOR `inj_mask`. Injection never alters the estimate or the tap history.
- R7: `repl_count` increases by one with every output that has `out_replaced` high. It stops at its all-ones value and stays there.
- R8: In a cycle where `out_valid` is low, `out_replaced` is 0, `out_data` keeps its last value and `repl_count` does not change. A cycle where `in_valid` is low leaves the tap history untouched, whatever is on `in_sample`, `inj_en` or `inj_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Accept `in_sample` this cycle |
| in_sample | input | 12 | Signed input sample |
| inj_en | input | 1 | Corrupt the precise result of this sample |
| inj_mask | input | 22 | Bits flipped in the precise result when `inj_en` is high |
| th | input | 22 | Unsigned replacement threshold, taken with the sample |
| out_valid | output | 1 | `out_data` holds a new result |
| out_data | output | 22 | Signed selected result |
| out_replaced | output | 1 | The estimate was chosen for this output |
| repl_count | output | 16 | Saturating count of replaced outputs |

## Verification
The assertions check the pipeline alignment on every cycle: the two paths deliver together, and each output arrives exactly two edges after its sample. They also check that the flag only appears with a valid output, and that the replacement counter steps by one, saturates and otherwise holds. Only the bench scenarios can show the arithmetic. They cover impulse and full-scale inputs through the precise filter, the truncated arithmetic of the estimator, and the decision at a gap exactly equal to the threshold and one above it. They also cover injected bit flips being caught, and idle cycles with junk on the inputs leaving the tap history untouched.

// File: rtl/anc_pkg.sv
// Shared types for the threshold-corrected FIR.
// Assumes nothing beyond a standard SystemVerilog package scope.
package anc_pkg;
    // Which path feeds the output for one sample.
    typedef enum logic {
        SEL_MAIN = 1'b0,
        SEL_EST  = 1'b1
    } sel_e;
endpackage

// File: rtl/anc_fir_main.sv
// Full-precision FIR path with bit-flip injection on its registered result.
// Assumes TAPS >= 2 and OW wide enough to hold the sum of TAPS products.
// The history shifts only on accepted samples.
module anc_fir_main #(
    parameter int TAPS = 4,
    parameter int SW   = 12,
    parameter int CW   = 8,
    parameter int OW   = 22,
    parameter logic [TAPS*CW-1:0] COEFFS = 32'h8065_C717
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [SW-1:0] in_sample,
    input  logic                 inj_en,
    input  logic [OW-1:0]        inj_mask,
    output logic                 res_valid,
    output logic signed [OW-1:0] res_data
);
    localparam int PW = SW + CW;

    logic signed [SW-1:0] hist_q [TAPS-1];
    logic signed [SW-1:0] tap_w  [TAPS];
    logic signed [PW-1:0] prod_w [TAPS];
    logic signed [OW-1:0] acc_w;

    for (genvar g = 0; g < TAPS; g++) begin : g_tap
        localparam logic signed [CW-1:0] COEF = COEFFS[g*CW +: CW];
        if (g == 0) begin : g_new
            assign tap_w[g] = in_sample;
        end else begin : g_old
            assign tap_w[g] = hist_q[g-1];
        end
        assign prod_w[g] = tap_w[g] * COEF;
    end

    // Sum all tap products at full width.
    always_comb begin
        acc_w = '0;
        for (int i = 0; i < TAPS; i++) begin
            acc_w = acc_w + OW'(prod_w[i]);
        end
    end

    // Register the result, apply injection, shift history on accepted samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
            for (int i = 0; i < TAPS-1; i++) hist_q[i] <= '0;
        end else begin
            res_valid <= in_valid;
            if (in_valid) begin
                res_data  <= acc_w ^ (inj_en ? inj_mask : '0);
                hist_q[0] <= in_sample;
                for (int i = 1; i < TAPS-1; i++) hist_q[i] <= hist_q[i-1];
            end
        end
    end
endmodule

// File: rtl/anc_fir_est.sv
// Reduced-precision FIR path: keeps the top EB bits of samples and coefficients,
// then shifts the sum back to the full-precision scale. No injection reaches it.
// Assumes EB <= SW and EB <= CW, and TAPS >= 2.
module anc_fir_est #(
    parameter int TAPS = 4,
    parameter int SW   = 12,
    parameter int CW   = 8,
    parameter int OW   = 22,
    parameter int EB   = 6,
    parameter logic [TAPS*CW-1:0] COEFFS = 32'h8065_C717
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [EB-1:0] in_top,
    output logic                 res_valid,
    output logic signed [OW-1:0] res_data
);
    localparam int SHIFT = (SW - EB) + (CW - EB);
    localparam int PW    = 2 * EB;

    logic signed [EB-1:0] hist_q [TAPS-1];
    logic signed [EB-1:0] tap_w  [TAPS];
    logic signed [PW-1:0] prod_w [TAPS];
    logic signed [OW-1:0] acc_w;

    for (genvar g = 0; g < TAPS; g++) begin : g_tap
        localparam logic signed [EB-1:0] COEF = COEFFS[g*CW + CW - 1 -: EB];
        if (g == 0) begin : g_new
            assign tap_w[g] = in_top;
        end else begin : g_old
            assign tap_w[g] = hist_q[g-1];
        end
        assign prod_w[g] = tap_w[g] * COEF;
    end

    // Sum the narrow products and realign to the precise scale.
    always_comb begin
        acc_w = '0;
        for (int i = 0; i < TAPS; i++) begin
            acc_w = acc_w + OW'(prod_w[i]);
        end
        acc_w = acc_w <<< SHIFT;
    end

    // Register the estimate and shift the narrow history on accepted samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
            for (int i = 0; i < TAPS-1; i++) hist_q[i] <= '0;
        end else begin
            res_valid <= in_valid;
            if (in_valid) begin
                res_data  <= acc_w;
                hist_q[0] <= in_top;
                for (int i = 1; i < TAPS-1; i++) hist_q[i] <= hist_q[i-1];
            end
        end
    end
endmodule

// File: rtl/anc_select.sv
// Compare-and-replace stage: takes the estimate when the gap to the precise
// result exceeds the threshold, keeps a saturating replacement tally.
// Assumes THW <= OW and that both inputs belong to the same sample.
module anc_select #(
    parameter int OW    = 22,
    parameter int THW   = 22,
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 m_valid,
    input  logic signed [OW-1:0] m_data,
    input  logic                 e_valid,
    input  logic signed [OW-1:0] e_data,
    input  logic [THW-1:0]       th,
    output logic                 out_valid,
    output logic signed [OW-1:0] out_data,
    output logic                 out_replaced,
    output logic [CNT_W-1:0]     repl_count
);
    import anc_pkg::*;

    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    logic signed [OW:0] diff_w;
    logic        [OW:0] mag_w;
    logic               pair_v;
    sel_e               sel_w;

    // Signed gap, its magnitude, and the path choice.
    always_comb begin
        diff_w = {m_data[OW-1], m_data} - {e_data[OW-1], e_data};
        mag_w  = diff_w[OW] ? (OW+1)'(-diff_w) : (OW+1)'(diff_w);
        pair_v = m_valid & e_valid;
        sel_w  = (mag_w > (OW+1)'(th)) ? SEL_EST : SEL_MAIN;
    end

    // Register the chosen value, flag and replacement tally.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_data     <= '0;
            out_replaced <= 1'b0;
            repl_count   <= '0;
        end else begin
            out_valid    <= pair_v;
            out_replaced <= pair_v && (sel_w == SEL_EST);
            if (pair_v) begin
                out_data <= (sel_w == SEL_EST) ? e_data : m_data;
                if (sel_w == SEL_EST && repl_count != CMAX) begin
                    repl_count <= repl_count + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/anc_corrector.sv
// Top: precise FIR and narrow estimator FIR in parallel, followed by a
// threshold decision. The threshold is registered with the sample, so every
// output is decided with the threshold that came in with its own sample.
module anc_corrector #(
    parameter int TAPS  = 4,
    parameter int SW    = 12,
    parameter int CW    = 8,
    parameter int OW    = 22,
    parameter int EB    = 6,
    parameter int THW   = 22,
    parameter int CNT_W = 16,
    parameter logic [TAPS*CW-1:0] COEFFS = 32'h8065_C717
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [SW-1:0] in_sample,
    input  logic                 inj_en,
    input  logic [OW-1:0]        inj_mask,
    input  logic [THW-1:0]       th,
    output logic                 out_valid,
    output logic signed [OW-1:0] out_data,
    output logic                 out_replaced,
    output logic [CNT_W-1:0]     repl_count
);
    logic                 main_valid;
    logic signed [OW-1:0] main_data;
    logic                 est_valid;
    logic signed [OW-1:0] est_data;
    logic [THW-1:0]       th_q;

    // Carry the threshold alongside its sample into the decision stage.
    always_ff @(posedge clk) begin
        if (!rst_n)        th_q <= '0;
        else if (in_valid) th_q <= th;
    end

    anc_fir_main #(
        .TAPS(TAPS), .SW(SW), .CW(CW), .OW(OW), .COEFFS(COEFFS)
    ) u_main (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .inj_en    (inj_en),
        .inj_mask  (inj_mask),
        .res_valid (main_valid),
        .res_data  (main_data)
    );

    anc_fir_est #(
        .TAPS(TAPS), .SW(SW), .CW(CW), .OW(OW), .EB(EB), .COEFFS(COEFFS)
    ) u_est (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_top    (in_sample[SW-1 -: EB]),
        .res_valid (est_valid),
        .res_data  (est_data)
    );

    anc_select #(
        .OW(OW), .THW(THW), .CNT_W(CNT_W)
    ) u_sel (
        .clk          (clk),
        .rst_n        (rst_n),
        .m_valid      (main_valid),
        .m_data       (main_data),
        .e_valid      (est_valid),
        .e_data       (est_data),
        .th           (th_q),
        .out_valid    (out_valid),
        .out_data     (out_data),
        .out_replaced (out_replaced),
        .repl_count   (repl_count)
    );
endmodule

// File: rtl/anc_corrector_chk.sv
// Checker bound into anc_corrector: pipeline alignment, flag qualification
// and counter behaviour. Assumes synchronous active-low reset.
module anc_corrector_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             out_valid,
    input logic             out_replaced,
    input logic [CNT_W-1:0] repl_count,
    input logic             m_valid,
    input logic             e_valid
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    logic [1:0] age_q;

    // Count cycles since reset, up to 3, to gate the two-cycle lookback.
    always_ff @(posedge clk) begin
        if (!rst_n)             age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 1'b1;
    end

    // R2
    path_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid == e_valid);

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R8
    flag_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_replaced |-> out_valid);

    // R8
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_replaced && age_q != 2'd0) |-> $stable(repl_count));

    // R7
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_replaced && $past(repl_count) != CMAX) |->
            (repl_count == CNT_W'($past(repl_count) + 1'b1)));

    // R7
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0 && $past(repl_count) == CMAX) |-> (repl_count == CMAX));
endmodule

bind anc_corrector anc_corrector_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .out_valid    (out_valid),
    .out_replaced (out_replaced),
    .repl_count   (repl_count),
    .m_valid      (main_valid),
    .e_valid      (est_valid)
);

// File: tb/sim_anc_corrector.sv
`timescale 1ns/1ps
// Bench: directed corners plus seeded random traffic, checked against a model.
module sim_anc_corrector;
    localparam int CNT_W = 6;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n;
    logic in_valid;
    logic signed [11:0] in_sample;
    logic inj_en;
    logic [21:0] inj_mask;
    logic [21:0] th;
    logic out_valid;
    logic signed [21:0] out_data;
    logic out_replaced;
    logic [CNT_W-1:0] repl_count;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    anc_corrector #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .inj_en(inj_en), .inj_mask(inj_mask), .th(th),
        .out_valid(out_valid), .out_data(out_data),
        .out_replaced(out_replaced), .repl_count(repl_count)
    );

    // Model state
    int coef [4] = '{23, -57, 101, -128};
    int hist [3];
    bit e1_v, e2_v, e1_r, e2_r, e1_i, e2_i;
    logic [21:0] e1_d, e2_d, last_d;
    int cnt;

    function automatic int f_main(int x);
        int s = coef[0] * x;
        for (int k = 1; k < 4; k++) s += coef[k] * hist[k-1];
        return s;
    endfunction

    function automatic int f_est(int x);
        int s = (coef[0] >>> 2) * (x >>> 6);
        for (int k = 1; k < 4; k++) s += (coef[k] >>> 2) * (hist[k-1] >>> 6);
        return s * 256;
    endfunction

    function automatic longint f_gap(int x, logic [21:0] m);
        logic [21:0] y = 22'(f_main(x)) ^ m;
        longint d = longint'($signed(y)) - longint'(f_est(x));
        return (d < 0) ? -d : d;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // Compare the outputs against the expectation from two cycles ago.
    task automatic check_out();
        if (e2_v) begin
            chk(out_valid == 1'b1, "R2 out_valid", out_valid, 1);
            chk(out_data == e2_d, e2_i ? "R6 data" : (e2_r ? "R4/R5 data" : "R3 data"),
                $signed(out_data), $signed(e2_d));
            chk(out_replaced == e2_r, "R5 replaced", out_replaced, e2_r);
            if (e2_r && cnt < CMAX) cnt++;
            chk(repl_count == cnt, "R7 count", repl_count, cnt);
            last_d = e2_d;
        end else begin
            chk(out_valid == 1'b0, "R8 idle valid", out_valid, 0);
            chk(out_replaced == 1'b0, "R8 idle replaced", out_replaced, 0);
            chk(out_data == last_d, "R8 data hold", $signed(out_data), $signed(last_d));
            chk(repl_count == cnt, "R8 count hold", repl_count, cnt);
        end
    endtask

    // One cycle: check, advance the model pipeline, drive the next inputs.
    task automatic cycle(input bit v, input int s, input bit inj, input logic [21:0] m,
                         input logic [21:0] t);
        @(negedge clk);
        check_out();
        e2_v = e1_v; e2_d = e1_d; e2_r = e1_r; e2_i = e1_i;
        e1_v = v; e1_r = 1'b0; e1_i = v && inj; e1_d = '0;
        if (v) begin
            logic [21:0] y = 22'(f_main(s)) ^ (inj ? m : 22'd0);
            e1_r = f_gap(s, inj ? m : 22'd0) > longint'(t);
            e1_d = e1_r ? 22'(f_est(s)) : y;
            hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = s;
        end
        in_valid = v; in_sample = 12'(s); inj_en = inj; inj_mask = m; th = t;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; in_valid = 0; in_sample = '0; inj_en = 0; inj_mask = '0; th = '0;
        hist = '{0, 0, 0};
        e1_v = 0; e2_v = 0; e1_r = 0; e2_r = 0; e1_i = 0; e2_i = 0;
        e1_d = '0; e2_d = '0; last_d = '0; cnt = 0;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(out_valid == 0, "R1 valid", out_valid, 0);
        chk(out_replaced == 0, "R1 replaced", out_replaced, 0);
        chk(out_data == 0, "R1 data", out_data, 0);
        chk(repl_count == 0, "R1 count", repl_count, 0);
        rst_n = 1'b1;

        // R3: impulse response of the precise path, never replaced
        cycle(1, 1000, 0, 0, 22'h3FFFFF);
        for (int i = 0; i < 4; i++) cycle(1, 0, 0, 0, 22'h3FFFFF);

        // R3: full-scale inputs of both signs
        for (int i = 0; i < 5; i++) cycle(1, -2048, 0, 0, 22'h3FFFFF);
        for (int i = 0; i < 5; i++) cycle(1, 2047, 0, 0, 22'h3FFFFF);

        // R4/R5: zero threshold exposes the estimate wherever it differs
        for (int i = 0; i < 8; i++) cycle(1, 300 * i - 1100, 0, 0, 22'd0);

        // R5: gap exactly at threshold keeps main, one below replaces
        for (int i = 0; i < 6; i++) begin
            int s = 517 - 211 * i;
            longint d = f_gap(s, 0);
            cycle(1, s, 0, 0, 22'(d));
            s = -s + 33;
            d = f_gap(s, 0);
            cycle(1, s, 0, 0, (d > 0) ? 22'(d - 1) : 22'd0);
        end

        // R8: idle cycles with junk inputs must not shift history
        for (int i = 0; i < 4; i++) begin
            cycle(1, 123 * i, 0, 0, 22'd50);
            cycle(0, 1999, 1, 22'h3FFFFF, 22'd0);
            cycle(0, -777, 0, 0, 22'd0);
        end

        // R6: high-order flips against a moderate threshold
        for (int i = 0; i < 8; i++)
            cycle(1, 64 * i - 200, 1, 22'(1) << (15 + (i % 7)), 22'd4000);

        // Random traffic
        for (int i = 0; i < 3000; i++) begin
            bit v = ($urandom_range(0, 3) != 0);
            bit inj = ($urandom_range(0, 7) == 0);
            logic [21:0] m = (22'(1) << $urandom_range(12, 21)) | 22'($urandom_range(0, 3));
            logic [21:0] t;
            case ($urandom_range(0, 4))
                0: t = 22'd0;
                1: t = 22'd100;
                2: t = 22'd1500;
                3: t = 22'd8000;
                default: t = 22'h3FFFFF;
            endcase
            cycle(v, $urandom_range(0, 4095) - 2048, inj, m, t);
        end

        // R7: force replacements until the counter saturates
        for (int i = 0; i < 80; i++) cycle(1, i * 17 - 600, 1, 22'h200000, 22'd0);
        for (int i = 0; i < 3; i++) cycle(0, 0, 0, 0, 22'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule